// File: doc/BRIEF.md
# Display Controller Power-Up Sequencer

This block brings a small colour display controller out of reset and leaves it ready to accept pixel data. After a `start` pulse it drives the controller's reset line high and then low. It then walks a fixed table of register writes and sends every byte over a write-only SPI link. A separate data/command line tells the controller whether each byte is a register index or a value.

Every byte is its own chip-select frame. A register write is two frames: the index with the data/command line low, then the value with it high. Two timed pauses follow the first two table entries, which both write to the current-reduction register. The pause length comes from a clock-frequency parameter, and a simulation parameter can shorten it. The sequence closes with one command byte that opens the controller's pixel memory port. The block then raises `done` and stays idle until the next `start`.

Top module: `disp_init_seq`

## Requirements
- R1: Each byte is sent in its own frame. `spi_cs_n` goes low, exactly 8 rising `spi_sclk` edges carry the byte MSB first, then `spi_cs_n` returns high. The link uses mode 0: `spi_sclk` idles low, `spi_mosi` changes only while `spi_sclk` is low, and it is sampled on the rising edge.
- R2: `lcd_dc` is 0 for register index bytes and for the closing command byte. It is 1 for value bytes. It does not change while `spi_cs_n` is low.
- R3: After an accepted `start`, `lcd_rst` is high for exactly RST_CYC cycles and then goes low. The first frame starts at least RST_CYC cycles after that fall. No frame is active while `lcd_rst` is high.
- R4: The (index, value) pairs are sent in this order: 04←03, 04←00, 3B←00, 02←01, 03←90, 80←01, 08←04, 09←05, 0A←05, 0B←9D, 0C←8C, 0D←57, 10←56, 11←4D, 12←46, 13←00, 14←01, 16←66, 28←7F, 29←00, 06←01, 05←00, 15←00 (hex). 28←7F selects 1/128 duty and 06←01 switches the display on.
- R5: The line is idle for at least the pause length between the end of the value frame of each of the first two pairs and the next frame. In the default build the pause is CLK_HZ/1000·PAUSE_MS cycles; with FAST_SIM=1 it is FAST_PAUSE_CYC cycles. Every other gap between frames is shorter than the pause.
- R6: After the last pair, one byte 0x22 goes out with `lcd_dc` low and no value byte follows. `done` rises after that frame has closed, with 47 frames sent in total.
- R7: `busy` is high from the cycle after an accepted `start` until `done` rises. `busy` and `done` are never high together. `done` stays high until the next `start`.
- R8: A `start` pulse while `busy` is high has no effect: no new reset pulse, and the byte stream is unchanged.
- R9: During and after `rst`: `spi_cs_n`=1, `spi_sclk`=0, `busy`=0, `done`=0, `lcd_rst`=0.
- R10: Within a frame, rising `spi_sclk` edges are exactly CLK_DIV system clock cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run the power-up sequence |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence complete, sticky until the next start |
| spi_sclk | output | 1 | SPI serial clock, mode 0 |
| spi_mosi | output | 1 | SPI serial data, MSB first |
| spi_cs_n | output | 1 | SPI chip select, active low, one frame per byte |
| lcd_dc | output | 1 | Data/command select: 0 = index or command, 1 = value |
| lcd_rst | output | 1 | Reset line to the display controller |

## Verification
Four rules hold on every cycle and are checked there:
- `lcd_dc` stays put and `spi_sclk` stays low around frame boundaries.
- `spi_mosi` holds still while the clock is high.
- `busy` and `done` are never high together.
- No frame is open while `lcd_rst` is high, and a reset pulse can only begin from the not-busy state.

The bench's scenarios show what no single cycle can:
- the full ordered stream of (data/command, byte) pairs;
- the lengths of the reset pulse and of the two pauses;
- that no other gap is that long;
- that a start pulse in the middle of the sequence leaves the stream intact.

// File: rtl/disp_init_pkg.sv
package disp_init_pkg;

    localparam int N_PAIRS = 23;
    localparam logic [7:0] PORT_CMD = 8'h22;

    typedef struct packed {
        logic [7:0] idx;
        logic [7:0] val;
        logic       pause;
    } pair_t;

    typedef enum logic [3:0] {
        C_IDLE, C_RHI, C_RLO, C_IDX, C_IDXW, C_VAL, C_VALW,
        C_DLY, C_PORT, C_PORTW, C_FIN
    } cstate_e;

    typedef enum logic [1:0] {T_IDLE, T_SHIFT, T_GAP} tstate_e;

    function automatic pair_t pair_at(input int unsigned i);
        pair_t p;
        p.pause = 1'b0;
        case (i)
            0:  begin p.idx = 8'h04; p.val = 8'h03; p.pause = 1'b1; end
            1:  begin p.idx = 8'h04; p.val = 8'h00; p.pause = 1'b1; end
            2:  begin p.idx = 8'h3B; p.val = 8'h00; end
            3:  begin p.idx = 8'h02; p.val = 8'h01; end
            4:  begin p.idx = 8'h03; p.val = 8'h90; end
            5:  begin p.idx = 8'h80; p.val = 8'h01; end
            6:  begin p.idx = 8'h08; p.val = 8'h04; end
            7:  begin p.idx = 8'h09; p.val = 8'h05; end
            8:  begin p.idx = 8'h0A; p.val = 8'h05; end
            9:  begin p.idx = 8'h0B; p.val = 8'h9D; end
            10: begin p.idx = 8'h0C; p.val = 8'h8C; end
            11: begin p.idx = 8'h0D; p.val = 8'h57; end
            12: begin p.idx = 8'h10; p.val = 8'h56; end
            13: begin p.idx = 8'h11; p.val = 8'h4D; end
            14: begin p.idx = 8'h12; p.val = 8'h46; end
            15: begin p.idx = 8'h13; p.val = 8'h00; end
            16: begin p.idx = 8'h14; p.val = 8'h01; end
            17: begin p.idx = 8'h16; p.val = 8'h66; end
            18: begin p.idx = 8'h28; p.val = 8'h7F; end
            19: begin p.idx = 8'h29; p.val = 8'h00; end
            20: begin p.idx = 8'h06; p.val = 8'h01; end
            21: begin p.idx = 8'h05; p.val = 8'h00; end
            default: begin p.idx = 8'h15; p.val = 8'h00; end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/disp_init_rom.sv
module disp_init_rom
    import disp_init_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] addr,
    output pair_t         entry
);
    always_comb entry = pair_at(32'(addr));
endmodule

// File: rtl/disp_spi_tx.sv
module disp_spi_tx
    import disp_init_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic [7:0] byte_in,
    input  logic       dc_in,
    output logic       tx_done,
    output logic       sclk,
    output logic       mosi,
    output logic       cs_n,
    output logic       dc
);
    localparam int HALF = CLK_DIV / 2;
    localparam int PW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [PW-1:0] PH_END = PW'(HALF - 1);

    typedef struct packed {
        tstate_e       st;
        logic [7:0]    sh;
        logic [2:0]    bitn;
        logic [PW-1:0] ph;
        logic          sclk;
        logic          cs_n;
        logic          dc;
    } tx_t;

    tx_t r_q, r_d;

    always_comb begin
        r_d     = r_q;
        tx_done = 1'b0;
        case (r_q.st)
            T_IDLE: begin
                if (go) begin
                    r_d.st   = T_SHIFT;
                    r_d.sh   = byte_in;
                    r_d.dc   = dc_in;
                    r_d.cs_n = 1'b0;
                    r_d.bitn = '0;
                    r_d.ph   = '0;
                    r_d.sclk = 1'b0;
                end
            end
            T_SHIFT: begin
                if (r_q.ph == PH_END) begin
                    r_d.ph = '0;
                    if (!r_q.sclk) begin
                        r_d.sclk = 1'b1;
                    end else begin
                        r_d.sclk = 1'b0;
                        if (r_q.bitn == 3'd7) begin
                            r_d.cs_n = 1'b1;
                            r_d.st   = T_GAP;
                        end else begin
                            r_d.sh   = {r_q.sh[6:0], 1'b0};
                            r_d.bitn = r_q.bitn + 3'd1;
                        end
                    end
                end else begin
                    r_d.ph = r_q.ph + PW'(1);
                end
            end
            T_GAP: begin
                if (r_q.ph == PH_END) begin
                    r_d.ph  = '0;
                    r_d.st  = T_IDLE;
                    tx_done = 1'b1;
                end else begin
                    r_d.ph = r_q.ph + PW'(1);
                end
            end
            default: r_d.st = T_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st   <= T_IDLE;
            r_q.sh   <= '0;
            r_q.bitn <= '0;
            r_q.ph   <= '0;
            r_q.sclk <= 1'b0;
            r_q.cs_n <= 1'b1;
            r_q.dc   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sclk = r_q.sclk;
    assign mosi = r_q.sh[7];
    assign cs_n = r_q.cs_n;
    assign dc   = r_q.dc;

    // R2
    dc_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!r_q.cs_n && $past(!r_q.cs_n)) |-> $stable(r_q.dc));

    // R1
    sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
        r_q.cs_n |-> !r_q.sclk);

    // R1
    mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (r_q.sclk && $past(r_q.sclk)) |-> $stable(r_q.sh[7]));

endmodule

// File: rtl/disp_init_ctrl.sv
module disp_init_ctrl
    import disp_init_pkg::*;
#(
    parameter int RST_CYC   = 16,
    parameter int PAUSE_CYC = 500000,
    parameter int AW        = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  pair_t         entry,
    input  logic          tx_done,
    output logic [AW-1:0] addr,
    output logic          go,
    output logic [7:0]    tx_byte,
    output logic          tx_dc,
    output logic          lcd_rst,
    output logic          busy,
    output logic          done
);
    localparam int CMAX = (RST_CYC > PAUSE_CYC) ? RST_CYC : PAUSE_CYC;
    localparam int CW   = $clog2(CMAX + 1);
    localparam logic [CW-1:0] RST_END   = CW'(RST_CYC - 1);
    localparam logic [CW-1:0] PAUSE_END = CW'(PAUSE_CYC - 1);
    localparam logic [AW-1:0] LAST      = AW'(N_PAIRS - 1);

    typedef struct packed {
        cstate_e       st;
        logic [AW-1:0] ent;
        logic [CW-1:0] cnt;
        logic          lrst;
        logic          done;
    } ctl_t;

    ctl_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            C_IDLE, C_FIN: begin
                if (start) begin
                    r_d.st   = C_RHI;
                    r_d.lrst = 1'b1;
                    r_d.done = 1'b0;
                    r_d.cnt  = '0;
                    r_d.ent  = '0;
                end
            end
            C_RHI: begin
                if (r_q.cnt == RST_END) begin
                    r_d.lrst = 1'b0;
                    r_d.cnt  = '0;
                    r_d.st   = C_RLO;
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            C_RLO: begin
                if (r_q.cnt == RST_END) begin
                    r_d.cnt = '0;
                    r_d.st  = C_IDX;
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            C_IDX:  r_d.st = C_IDXW;
            C_IDXW: if (tx_done) r_d.st = C_VAL;
            C_VAL:  r_d.st = C_VALW;
            C_VALW: begin
                if (tx_done) begin
                    if (entry.pause) begin
                        r_d.st  = C_DLY;
                        r_d.cnt = '0;
                    end else if (r_q.ent == LAST) begin
                        r_d.st = C_PORT;
                    end else begin
                        r_d.ent = r_q.ent + AW'(1);
                        r_d.st  = C_IDX;
                    end
                end
            end
            C_DLY: begin
                if (r_q.cnt == PAUSE_END) begin
                    r_d.cnt = '0;
                    if (r_q.ent == LAST) begin
                        r_d.st = C_PORT;
                    end else begin
                        r_d.ent = r_q.ent + AW'(1);
                        r_d.st  = C_IDX;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            C_PORT:  r_d.st = C_PORTW;
            C_PORTW: begin
                if (tx_done) begin
                    r_d.st   = C_FIN;
                    r_d.done = 1'b1;
                end
            end
            default: r_d.st = C_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st   <= C_IDLE;
            r_q.ent  <= '0;
            r_q.cnt  <= '0;
            r_q.lrst <= 1'b0;
            r_q.done <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        go      = (r_q.st == C_IDX) || (r_q.st == C_VAL) || (r_q.st == C_PORT);
        tx_dc   = (r_q.st == C_VAL);
        tx_byte = (r_q.st == C_VAL)  ? entry.val :
                  (r_q.st == C_PORT) ? PORT_CMD  : entry.idx;
    end

    assign addr    = r_q.ent;
    assign lcd_rst = r_q.lrst;
    assign done    = r_q.done;
    assign busy    = (r_q.st != C_IDLE) && (r_q.st != C_FIN);

    // R7
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    // R8
    rst_pulse_origin_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lcd_rst) |-> $past(!busy));

endmodule

// File: rtl/disp_init_seq.sv
module disp_init_seq
    import disp_init_pkg::*;
#(
    parameter int CLK_DIV        = 4,
    parameter int CLK_HZ         = 100_000_000,
    parameter int PAUSE_MS       = 5,
    parameter int FAST_SIM       = 0,
    parameter int FAST_PAUSE_CYC = 200,
    parameter int RST_CYC        = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done,
    output logic spi_sclk,
    output logic spi_mosi,
    output logic spi_cs_n,
    output logic lcd_dc,
    output logic lcd_rst
);
    localparam int PAUSE_CYC = (FAST_SIM != 0) ? FAST_PAUSE_CYC : (CLK_HZ / 1000) * PAUSE_MS;
    localparam int AW        = $clog2(N_PAIRS);

    logic [AW-1:0] addr;
    pair_t         entry;
    logic          go, tx_done, tx_dc;
    logic [7:0]    tx_byte;

    disp_init_rom #(.AW(AW)) i_rom (
        .addr (addr),
        .entry(entry)
    );

    disp_init_ctrl #(.RST_CYC(RST_CYC), .PAUSE_CYC(PAUSE_CYC), .AW(AW)) i_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .entry  (entry),
        .tx_done(tx_done),
        .addr   (addr),
        .go     (go),
        .tx_byte(tx_byte),
        .tx_dc  (tx_dc),
        .lcd_rst(lcd_rst),
        .busy   (busy),
        .done   (done)
    );

    disp_spi_tx #(.CLK_DIV(CLK_DIV)) i_tx (
        .clk    (clk),
        .rst    (rst),
        .go     (go),
        .byte_in(tx_byte),
        .dc_in  (tx_dc),
        .tx_done(tx_done),
        .sclk   (spi_sclk),
        .mosi   (spi_mosi),
        .cs_n   (spi_cs_n),
        .dc     (lcd_dc)
    );

    // R3
    no_frame_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
        lcd_rst |-> spi_cs_n);

endmodule

// File: tb/test_disp_init_seq.sv
module test_disp_init_seq;
    localparam int CLK_DIV = 4;
    localparam int PAUSE   = 200;
    localparam int RSTC    = 8;
    localparam int NFR     = 47;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic busy, done, spi_sclk, spi_mosi, spi_cs_n, lcd_dc, lcd_rst;

    always #2.5 clk = ~clk;

    disp_init_seq #(
        .CLK_DIV(CLK_DIV), .CLK_HZ(100_000_000), .PAUSE_MS(5),
        .FAST_SIM(1), .FAST_PAUSE_CYC(PAUSE), .RST_CYC(RSTC)
    ) i_disp_init_seq (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n),
        .lcd_dc(lcd_dc), .lcd_rst(lcd_rst)
    );

    int checks = 0, fails = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected stream (R4, R6)
    logic [7:0] exp_b [NFR];
    logic       exp_dc[NFR];
    initial begin
        logic [7:0] ti[23] = '{8'h04,8'h04,8'h3B,8'h02,8'h03,8'h80,8'h08,8'h09,8'h0A,8'h0B,
                               8'h0C,8'h0D,8'h10,8'h11,8'h12,8'h13,8'h14,8'h16,8'h28,8'h29,
                               8'h06,8'h05,8'h15};
        logic [7:0] tv[23] = '{8'h03,8'h00,8'h00,8'h01,8'h90,8'h01,8'h04,8'h05,8'h05,8'h9D,
                               8'h8C,8'h57,8'h56,8'h4D,8'h46,8'h00,8'h01,8'h66,8'h7F,8'h00,
                               8'h01,8'h00,8'h00};
        for (int k = 0; k < 23; k++) begin
            exp_b[2*k] = ti[k]; exp_dc[2*k] = 1'b0;
            exp_b[2*k+1] = tv[k]; exp_dc[2*k+1] = 1'b1;
        end
        exp_b[NFR-1] = 8'h22; exp_dc[NFR-1] = 1'b0;
    end

    // SPI decoder, sampled at the falling system clock edge
    logic [7:0] got_b [64];
    logic       got_dc[64];
    int         got_bits[64], fr_beg[64], fr_end[64];
    bit         fr_bad[64];
    int nfr = 0, bits = 0, last_rise = 0, rst_rises = 0;
    int rst_hi_beg = 0, rst_hi_len = 0, rst_fall = 0;
    int busy_viol = 0;
    bit monitor_busy = 0;
    logic [7:0] shreg = '0;
    logic p_sclk = 1'b0, p_cs = 1'b1, p_dc = 1'b0, p_rst = 1'b0, p_mosi = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (p_cs && !spi_cs_n && nfr < 64) begin
                bits = 0; shreg = '0; fr_beg[nfr] = cyc; fr_bad[nfr] = 0;
            end
            if (!spi_cs_n && nfr < 64) begin
                if (!p_sclk && spi_sclk) begin
                    if (bits > 0 && cyc - last_rise != CLK_DIV) fr_bad[nfr] = 1;
                    shreg = {shreg[6:0], spi_mosi}; bits++; last_rise = cyc;
                end
                if (p_sclk && spi_sclk && spi_mosi != p_mosi) fr_bad[nfr] = 1;
                if (!p_cs && lcd_dc != p_dc) fr_bad[nfr] = 1;
            end
            if (!p_cs && spi_cs_n && nfr < 64) begin
                got_b[nfr] = shreg; got_dc[nfr] = p_dc; got_bits[nfr] = bits;
                fr_end[nfr] = cyc; nfr++;
            end
            if (!p_rst && lcd_rst) begin rst_rises++; rst_hi_beg = cyc; end
            if (p_rst && !lcd_rst) begin rst_hi_len = cyc - rst_hi_beg; rst_fall = cyc; end
            if (monitor_busy && !done && !busy) busy_viol++;
            if (busy && done) busy_viol++;
        end
        p_sclk = spi_sclk; p_cs = spi_cs_n; p_dc = lcd_dc; p_rst = lcd_rst; p_mosi = spi_mosi;
    end

    task automatic summary_and_end();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #800000;
        chk(0, "watchdog", cyc, 0);
        summary_and_end();
    end

    task automatic run_seq(input bit poke);
        nfr = 0; rst_rises = 0; busy_viol = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy == 1'b1 && done == 1'b0, "R7 busy after start", {busy, done}, 2);
        monitor_busy = 1;
        if (poke) begin
            while (nfr < 10) @(negedge clk);
            start = 1'b1; @(negedge clk); start = 1'b0;
            while (nfr < 2) @(negedge clk);
        end
        while (!done) @(negedge clk);
        monitor_busy = 0;
        chk(rst_rises == 1, "R8 single reset pulse", rst_rises, 1);
        chk(rst_hi_len == RSTC, "R3 reset high length", rst_hi_len, RSTC);
        chk(fr_beg[0] - rst_fall >= RSTC, "R3 reset low before first frame",
            fr_beg[0] - rst_fall, RSTC);
        chk(nfr == NFR, "R6 frame count at done", nfr, NFR);
        chk(busy_viol == 0, "R7 busy span", busy_viol, 0);
        for (int k = 0; k < NFR; k++) begin
            chk(got_b[k] == exp_b[k], poke ? "R8 byte" : "R4 byte", got_b[k], exp_b[k]);
            chk(got_dc[k] == exp_dc[k], "R2 dc level", got_dc[k], exp_dc[k]);
            chk(got_bits[k] == 8 && !fr_bad[k], "R1 R10 frame shape", got_bits[k], 8);
            if (k < NFR - 1) begin
                if (k == 1 || k == 3)
                    chk(fr_beg[k+1] - fr_end[k] >= PAUSE, "R5 pause present",
                        fr_beg[k+1] - fr_end[k], PAUSE);
                else
                    chk(fr_beg[k+1] - fr_end[k] < PAUSE, "R5 no pause",
                        fr_beg[k+1] - fr_end[k], PAUSE);
            end
        end
        repeat (50) @(negedge clk);
        chk(done && !busy && spi_cs_n && nfr == NFR, "R7 done sticky, R6 nothing after",
            {done, busy}, 2);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(!busy && !done && spi_cs_n && !spi_sclk && !lcd_rst, "R9 reset state",
            {busy, done, spi_cs_n, spi_sclk, lcd_rst}, 4);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && spi_cs_n && !lcd_rst, "R9 idle after reset",
            {busy, done, spi_cs_n, lcd_rst}, 2);
        run_seq(1'b0);
        run_seq(1'b1);
        summary_and_end();
    end
endmodule